// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device holds wedged with SDA low, as can happen after a transfer is cut short. When it accepts a request, it takes control of both lines as open-drain drivers. It lets SDA float high, then clocks SCL for as long as SDA still reads low. Before each clock it waits for any clock stretching to end. It closes with a start condition and then a stop condition, so that every target's bus state machine returns to idle.

All timing comes from one step length, given as a count of system clock cycles. Each phase of a clock pulse and each stage of the start/stop pattern lasts one step. The sequencer gives up in two cases: SDA is still low after the pulse budget is spent, or SCL stays low for too many polls. In both cases it releases both lines and reports an error. The controller that owns the bus triggers the sequence and waits for `done_o`.

Top module: `bus_unwedge`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `error_o` are 0, and neither line is pulled low (`scl_oe_o` = `sda_oe_o` = 0, where 1 means pull low).
- R2: A `start_i` seen while idle makes `busy_o` high from the next cycle. At that point both lines are released, before any SCL pulse.
- R3: Recovery SCL pulses (SCL pulled low while SDA is released) occur only while synchronized SDA reads low. When SDA reads high after k pulses, with k no more than the pulse budget (default 9), exactly k pulses have been issued and the sequence succeeds.
- R4: If SDA still reads low after the budget of pulses, the sequence aborts with `error_o` = 1. No further pulse is issued.
- R5: A pulse starts only after synchronized SCL reads high. Each poll that finds SCL low waits one step. The sequence aborts with an error, having issued no pulse, once more than the poll limit (default 10) of such waits have passed.
- R6: Every SCL pull-low lasts exactly STEP_CYCLES clock cycles. This covers both recovery pulses and the low phase of the start/stop pattern.
- R7: On success, the block pulls SDA low while SCL is released (start condition). It then pulls SCL low, releases SCL, and releases SDA while SCL is released (stop condition). Each of these stages lasts one step. `done_o` follows with `error_o` = 0.
- R8: On an abort, both lines are released when `done_o` is high with `error_o` = 1. No start or stop condition is produced.
- R9: A `start_i` that arrives while `busy_o` is high is ignored: exactly one `done_o` results.
- R10: `done_o` is a single-cycle pulse. `busy_o` stays high up to and including that cycle and is low in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Result of the last sequence, 1 = aborted; valid with done_o |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong pulse counter or a wrong limit compare shows up as a pulse count that differs from the number of clocks the target model needed. It can also show up as an error flag that has the wrong value when done_o rises. Either difference is visible within one step of the decision. A wrong line-enable decode shows as an extra or missing start or stop edge, or as an SCL low phase whose length differs from STEP_CYCLES. The monitor catches both within the same step. A state machine that ignores stretching, or counts polls wrongly, pulls SCL while the target still holds it. It may instead finish without error under a clock that never rises. Either way the failure shows before or at done_o.

// File: rtl/bus_unwedge_pkg.sv
package bus_unwedge_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CHK_SDA,
    ST_CHK_SCL,
    ST_STRETCH,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_SP_SDA_LO,
    ST_SP_SCL_LO,
    ST_SP_SCL_HI,
    ST_SP_SDA_HI,
    ST_ABORT,
    ST_FIN
  } unwedge_state_e;

  function automatic logic drives_scl_low(unwedge_state_e s);
    return (s == ST_PULSE_LO) || (s == ST_SP_SCL_LO);
  endfunction

  function automatic logic drives_sda_low(unwedge_state_e s);
    return (s == ST_SP_SDA_LO) || (s == ST_SP_SCL_LO) || (s == ST_SP_SCL_HI);
  endfunction

endpackage

// File: rtl/unwedge_sync.sv
module unwedge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus reads high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/unwedge_step_timer.sv
module unwedge_step_timer #(
  parameter int STEP_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);

  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_clr_restarts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/unwedge_ctrl.sv
module unwedge_ctrl
  import bus_unwedge_pkg::*;
#(
  parameter int MAX_PULSES  = 9,
  parameter int MAX_STRETCH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic tick_i,
  output logic step_clr_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam int SW = $clog2(MAX_STRETCH + 2);
  localparam logic [PW-1:0] PULSE_LIM   = PW'(MAX_PULSES);
  localparam logic [SW-1:0] STRETCH_LIM = SW'(MAX_STRETCH);

  unwedge_state_e state_q, state_d;
  logic [PW-1:0]  pulse_q, pulse_d;
  logic [SW-1:0]  stretch_q, stretch_d;
  logic           err_q, err_d;

  always_comb begin
    state_d   = state_q;
    pulse_d   = pulse_q;
    stretch_d = stretch_q;
    err_d     = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETTLE;
        pulse_d = '0;
        err_d   = 1'b0;
      end
      ST_SETTLE:   if (tick_i) state_d = ST_CHK_SDA;
      ST_CHK_SDA: begin
        if (sda_s_i)                 state_d = ST_SP_SDA_LO;
        else if (pulse_q >= PULSE_LIM) state_d = ST_ABORT;
        else begin
          state_d   = ST_CHK_SCL;
          stretch_d = '0;
        end
      end
      ST_CHK_SCL: begin
        if (scl_s_i) begin
          state_d = ST_PULSE_LO;
          pulse_d = pulse_q + 1'b1;
        end else if (stretch_q > STRETCH_LIM) begin
          state_d = ST_ABORT;
        end else begin
          state_d   = ST_STRETCH;
          stretch_d = stretch_q + 1'b1;
        end
      end
      ST_STRETCH:   if (tick_i) state_d = ST_CHK_SCL;
      ST_PULSE_LO:  if (tick_i) state_d = ST_PULSE_HI;
      ST_PULSE_HI:  if (tick_i) state_d = ST_CHK_SDA;
      ST_SP_SDA_LO: if (tick_i) state_d = ST_SP_SCL_LO;
      ST_SP_SCL_LO: if (tick_i) state_d = ST_SP_SCL_HI;
      ST_SP_SCL_HI: if (tick_i) state_d = ST_SP_SDA_HI;
      ST_SP_SDA_HI: if (tick_i) state_d = ST_FIN;
      ST_ABORT: begin
        state_d = ST_FIN;
        err_d   = 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pulse_q   <= '0;
      stretch_q <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      pulse_q   <= pulse_d;
      stretch_q <= stretch_d;
      err_q     <= err_d;
    end
  end

  assign step_clr_o = (state_d != state_q);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign error_o    = err_q;
  assign scl_oe_o   = drives_scl_low(state_q);
  assign sda_oe_o   = drives_sda_low(state_q);

  p_pulse_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q <= PULSE_LIM);

  p_scl_high_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) && !sda_oe_o |-> $past(scl_s_i));

  p_stop_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o);

  p_start_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_oe_o);

  p_abort_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && error_o |-> !scl_oe_o && !sda_oe_o);

  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

endmodule

// File: rtl/bus_unwedge.sv
module bus_unwedge #(
  parameter int STEP_CYCLES = 500,
  parameter int MAX_PULSES  = 9,
  parameter int MAX_STRETCH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic error_o,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o
);

  logic [1:0] line_s;
  logic       step_clr, step_tick;

  unwedge_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  unwedge_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (step_clr),
    .tick_o (step_tick)
  );

  unwedge_ctrl #(.MAX_PULSES(MAX_PULSES), .MAX_STRETCH(MAX_STRETCH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .tick_i     (step_tick),
    .step_clr_o (step_clr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

endmodule

// File: tb/sim_bus_unwedge.sv
`timescale 1ns/1ps
module sim_bus_unwedge;

  localparam int STEP = 4;
  localparam int MAXP = 9;
  localparam int MAXS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, err, scl_oe, sda_oe;
  logic tgt_sda_low = 1'b0;
  int   tgt_hold_k = 0;
  int   stretch_left = 0;
  logic scl_line, sda_line;

  assign scl_line = !scl_oe && !(stretch_left > 0);
  assign sda_line = !sda_oe && !tgt_sda_low;

  always #10 clk = ~clk;

  bus_unwedge #(.STEP_CYCLES(STEP), .MAX_PULSES(MAXP), .MAX_STRETCH(MAXS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .error_o(err),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int checks = 0;
  int fails  = 0;

  // bus monitor and target model, sampled on the falling edge
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  int pulses = 0, starts = 0, stops = 0, bad_width = 0, stretch_viol = 0;
  int dones = 0, low_run = 0;

  always @(negedge clk) begin
    if (scl_oe) low_run <= low_run + 1;
    else low_run <= 0;
    if (!scl_oe && prev_scl && low_run != STEP) bad_width <= bad_width + 1;
    if (scl_oe && !prev_scl && !sda_oe) begin
      pulses <= pulses + 1;
      if (pulses + 1 >= tgt_hold_k) tgt_sda_low <= 1'b0;
      if (stretch_left > 0) stretch_viol <= stretch_viol + 1;
    end
    if (sda_oe && !prev_sda && !scl_oe) starts <= starts + 1;
    if (!sda_oe && prev_sda && !scl_oe) stops <= stops + 1;
    if (done) dones <= dones + 1;
    if (stretch_left > 0 && stretch_left < 100000) stretch_left <= stretch_left - 1;
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int k, input int stretch, input bit restart_mid);
    int exp_p, exp_e, t;
    @(negedge clk);
    pulses = 0; starts = 0; stops = 0; bad_width = 0; stretch_viol = 0; dones = 0;
    tgt_hold_k   = k;
    tgt_sda_low  = (k > 0);
    stretch_left = stretch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 lines released", {scl_oe, sda_oe}, 0);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (restart_mid && t == 20) start = 1'b1;
      if (restart_mid && t == 21) start = 1'b0;
    end
    if (t >= 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      return;
    end
    if (stretch >= 100000) begin
      exp_p = 0; exp_e = 1;
    end else begin
      exp_p = (k > MAXP) ? MAXP : k;
      exp_e = (k > MAXP) ? 1 : 0;
    end
    check(exp_e ? "R4/R5 error flag" : "R7 success flag", err, exp_e);
    check("R3 pulse count", pulses, exp_p);
    check("R7 start conditions", starts, exp_e ? 0 : 1);
    check("R7 stop conditions", stops, exp_e ? 0 : 1);
    check("R6 low phase width", bad_width, 0);
    check("R5 pulse during stretch", stretch_viol, 0);
    if (exp_e) check("R8 released at abort", {scl_oe, sda_oe}, 0);
    @(negedge clk);
    check("R10 done single cycle", done, 0);
    check("R10 busy low after done", busy, 0);
    repeat (40) @(negedge clk);
    check("R9 one done per request", dones, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 error reset", err, 0);
    check("R1 lines reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k <= MAXP + 2; k++) run(k, 0, 1'b0);  // R3 R4 sweep
    run(3, 3 * STEP, 1'b0);                              // R5 short stretch
    run(1, 7 * STEP + 1, 1'b0);                          // R5 longer stretch
    run(5, 200000, 1'b0);                                // R5 stuck clock
    stretch_left = 0;
    run(4, 0, 1'b1);                                     // R9 restart while busy
    run(MAXP, 0, 1'b1);                                  // R4 boundary with restart
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule